// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit forms the linear memory address of one operand of a variable-length, register-rich instruction. The decode stage supplies an addressing-mode code, the base and index register values, a scale code, a raw displacement with a size code, an operand size, a segment value and the translation mode. The unit builds an offset from these inputs, then adds a segment base. In real mode the segment base is the segment value moved up by four bits. In protected mode the segment value selects an entry of a small internal descriptor table.

The auto-increment and auto-decrement modes update the base register as a side effect. The new base value comes back as a register write-back with its own valid flag. One register stage separates the inputs from the results. An undefined mode code yields an error flag and no side effect.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode code 0 gives the sign-extended displacement as offset, code 1 gives base, code 3 gives base plus index.
- R2: Mode codes 2, 4 and 6 add the displacement to the offset of codes 1, 3 and 5. The displacement is sign-extended from 8 bits (size code 0), 16 bits (size code 1) or taken as 32 bits (size codes 2 and 3).
- R3: In mode codes 5 and 6 the index is shifted left by the 2-bit scale code (x1, x2, x4, x8). Codes 3 and 4 ignore the scale code.
- R4: With prot_en low, the address is (segment value shifted left 4 + offset) modulo 2^20.
- R5: With prot_en high and full_en high, the address is (descriptor entry selected by the low 3 bits of the segment value + offset) modulo 2^32.
- R6: With prot_en high and full_en low, only the low 24 bits of the entry are used and the address is taken modulo 2^24.
- R7: Mode code 7 (auto-increment) uses base as the offset and writes back base + 2^op_sz, modulo 2^32, with wb_valid high.
- R8: Mode code 8 (auto-decrement) writes back base - 2^op_sz, modulo 2^32, and uses that value as the offset. Only codes 7 and 8 raise wb_valid.
- R9: A cycle with in_valid high produces out_valid high exactly one clock later. A cycle with in_valid low gives all outputs zero one clock later.
- R10: Mode codes 9 to 15 give out_err high, out_addr zero and wb_valid low.
- R11: With dt_we high, dt_base is stored into entry dt_idx at the clock edge. A lookup in the same cycle sees the previous content.
- R12: Reset clears all outputs and every descriptor entry to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand request valid |
| mode | input | 4 | Addressing-mode code |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale | input | 2 | Index shift amount |
| disp | input | 32 | Raw displacement |
| disp_sz | input | 2 | Displacement width code |
| op_sz | input | 2 | Operand size, 2^op_sz bytes |
| seg | input | 16 | Segment value |
| prot_en | input | 1 | Protected translation when high |
| full_en | input | 1 | 32-bit descriptor bases when high |
| dt_we | input | 1 | Descriptor table write enable |
| dt_idx | input | 3 | Descriptor entry to write |
| dt_base | input | 32 | Descriptor base to write |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Linear address |
| out_err | output | 1 | Undefined mode code seen |
| wb_valid | output | 1 | Base write-back valid |
| wb_data | output | 32 | Updated base register value |

## Verification
The assertions check several properties on every cycle. They check the one-cycle latency and the all-zero idle output. They check that an error result is a zero address with no write-back, and that write-back appears only for the two update modes. They also check the auto-increment value and the address range limits of real and reduced translation. The exact arithmetic of each offset form cannot be shown by those properties. The same holds for sign extension at each displacement width, the descriptor contents, and the old-value behaviour of a same-cycle table write. The bench shows these by comparing every output against its own model over directed and pseudo-random sequences.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int ADDR_W   = 32;
    localparam int SEG_W    = 16;
    localparam int DT_DEPTH = 8;
    localparam int RM_SHIFT = 4;
    localparam int RM_AW    = 20;
    localparam int RED_AW   = 24;

    typedef enum logic [3:0] {
        AM_ABS       = 4'd0,
        AM_B         = 4'd1,
        AM_B_D       = 4'd2,
        AM_B_I       = 4'd3,
        AM_B_I_D     = 4'd4,
        AM_B_SI      = 4'd5,
        AM_B_SI_D    = 4'd6,
        AM_POST_INC  = 4'd7,
        AM_PRE_DEC   = 4'd8
    } addr_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] offset;
        logic              wb_en;
        logic [ADDR_W-1:0] wb_val;
        logic              bad;
    } off_res_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic              wb_valid;
        logic [ADDR_W-1:0] wb_data;
    } stage_t;

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [ADDR_W-1:0] d,
                                                     input logic [1:0] sz);
        logic [ADDR_W-1:0] r;
        case (sz)
            2'd0:    r = {{(ADDR_W-8){d[7]}}, d[7:0]};
            2'd1:    r = {{(ADDR_W-16){d[15]}}, d[15:0]};
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] low_mask(input int bits);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) m[i] = (i < bits);
        return m;
    endfunction
endpackage

// File: rtl/eag_offset.sv
module eag_offset
    import eag_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [1:0]    scale,
    input  logic [AW-1:0] disp,
    input  logic [1:0]    disp_sz,
    input  logic [1:0]    op_sz,
    output off_res_t      res
);
    logic [AW-1:0] disp_x;
    logic [AW-1:0] idx_sc;
    logic [AW-1:0] step;
    logic [AW-1:0] dec_val;

    assign disp_x  = sext_disp(disp, disp_sz);
    assign idx_sc  = index << scale;
    assign step    = AW'(1) << op_sz;
    assign dec_val = base - step;

    always_comb begin
        res = '0;
        case (mode)
            AM_ABS:      res.offset = disp_x;
            AM_B:        res.offset = base;
            AM_B_D:      res.offset = base + disp_x;
            AM_B_I:      res.offset = base + index;
            AM_B_I_D:    res.offset = base + index + disp_x;
            AM_B_SI:     res.offset = base + idx_sc;
            AM_B_SI_D:   res.offset = base + idx_sc + disp_x;
            AM_POST_INC: begin
                res.offset = base;
                res.wb_en  = 1'b1;
                res.wb_val = base + step;
            end
            AM_PRE_DEC: begin
                res.offset = dec_val;
                res.wb_en  = 1'b1;
                res.wb_val = dec_val;
            end
            default:     res.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/eag_segxlat.sv
module eag_segxlat
    import eag_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int SW    = SEG_W,
    parameter int DEPTH = DT_DEPTH,
    parameter int SHIFT = RM_SHIFT,
    parameter int RAW   = RM_AW,
    parameter int PAW   = RED_AW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SW-1:0]            seg,
    input  logic                     prot_en,
    input  logic                     full_en,
    input  logic                     dt_we,
    input  logic [$clog2(DEPTH)-1:0] dt_idx,
    input  logic [AW-1:0]            dt_base,
    output logic [AW-1:0]            seg_base,
    output logic [AW-1:0]            addr_mask
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [AW-1:0] M_REAL = low_mask(RAW);
    localparam logic [AW-1:0] M_RED  = low_mask(PAW);

    logic [AW-1:0] tbl [DEPTH];
    logic [AW-1:0] entry;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                tbl[g] <= '0;
            else if (dt_we && dt_idx == IW'(g))
                tbl[g] <= dt_base;
        end
    end

    assign entry = tbl[seg[IW-1:0]];

    always_comb begin
        if (!prot_en) begin
            seg_base  = AW'(seg) << SHIFT;
            addr_mask = M_REAL;
        end else if (full_en) begin
            seg_base  = entry;
            addr_mask = '1;
        end else begin
            seg_base  = entry & M_RED;
            addr_mask = M_RED;
        end
    end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int SW    = SEG_W,
    parameter int DEPTH = DT_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [3:0]               mode,
    input  logic [AW-1:0]            base,
    input  logic [AW-1:0]            index,
    input  logic [1:0]               scale,
    input  logic [AW-1:0]            disp,
    input  logic [1:0]               disp_sz,
    input  logic [1:0]               op_sz,
    input  logic [SW-1:0]            seg,
    input  logic                     prot_en,
    input  logic                     full_en,
    input  logic                     dt_we,
    input  logic [$clog2(DEPTH)-1:0] dt_idx,
    input  logic [AW-1:0]            dt_base,
    output logic                     out_valid,
    output logic [AW-1:0]            out_addr,
    output logic                     out_err,
    output logic                     wb_valid,
    output logic [AW-1:0]            wb_data
);
    off_res_t      ores;
    logic [AW-1:0] sbase;
    logic [AW-1:0] amask;
    stage_t        nxt;
    stage_t        q;

    eag_offset #(.AW(AW)) u_off (
        .mode(mode), .base(base), .index(index), .scale(scale),
        .disp(disp), .disp_sz(disp_sz), .op_sz(op_sz), .res(ores)
    );

    eag_segxlat #(.AW(AW), .SW(SW), .DEPTH(DEPTH)) u_seg (
        .clk(clk), .rst(rst), .seg(seg), .prot_en(prot_en), .full_en(full_en),
        .dt_we(dt_we), .dt_idx(dt_idx), .dt_base(dt_base),
        .seg_base(sbase), .addr_mask(amask)
    );

    always_comb begin
        nxt = '0;
        if (in_valid) begin
            nxt.valid = 1'b1;
            nxt.err   = ores.bad;
            if (!ores.bad) begin
                nxt.addr     = (sbase + ores.offset) & amask;
                nxt.wb_valid = ores.wb_en;
                nxt.wb_data  = ores.wb_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign out_valid = q.valid;
    assign out_err   = q.err;
    assign out_addr  = q.addr;
    assign wb_valid  = q.wb_valid;
    assign wb_data   = q.wb_data;
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [3:0]    mode,
    input logic [AW-1:0] base,
    input logic [1:0]    op_sz,
    input logic          prot_en,
    input logic          full_en,
    input logic          out_valid,
    input logic [AW-1:0] out_addr,
    input logic          out_err,
    input logic          wb_valid,
    input logic [AW-1:0] wb_data
);
    p_lat_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wb_valid && !out_err && out_addr == '0));
    p_err_r10: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_addr == '0 && !wb_valid && out_valid));
    p_real_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !prot_en) |=> (out_addr[AW-1:20] == '0));
    p_red_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && prot_en && !full_en) |=> (out_addr[AW-1:24] == '0));
    p_inc_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 4'd7) |=>
            (wb_valid && wb_data == $past(base) + (AW'(1) << $past(op_sz))));
    p_wb_only_auto_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != 4'd7 && mode != 4'd8) |=> !wb_valid);
endmodule

bind eff_addr_gen eag_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .base(base),
    .op_sz(op_sz), .prot_en(prot_en), .full_en(full_en),
    .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err),
    .wb_valid(wb_valid), .wb_data(wb_data)
);

// File: tb/eff_addr_gen_tb_top.sv
module eff_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  mode;
    logic [31:0] base, index, disp, dt_base;
    logic [1:0]  scale, disp_sz, op_sz;
    logic [15:0] seg;
    logic        prot_en, full_en, dt_we;
    logic [2:0]  dt_idx;
    logic        out_valid, out_err, wb_valid;
    logic [31:0] out_addr, wb_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] mtbl [8];
    logic        e_valid, e_err, e_wbv;
    logic [31:0] e_addr, e_wb;
    string       e_tag;
    logic [31:0] rnd = 32'h1234_5678;

    always #4 clk = ~clk;

    eff_addr_gen dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .base(base),
        .index(index), .scale(scale), .disp(disp), .disp_sz(disp_sz),
        .op_sz(op_sz), .seg(seg), .prot_en(prot_en), .full_en(full_en),
        .dt_we(dt_we), .dt_idx(dt_idx), .dt_base(dt_base),
        .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err),
        .wb_valid(wb_valid), .wb_data(wb_data)
    );

    function automatic logic [31:0] nrand();
        rnd = rnd * 32'd1664525 + 32'd1013904223;
        return rnd;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: computes the expected result and updates the table image.
    task automatic model();
        longint unsigned dx, off, sb, lim, n;
        string otag, stag;
        n = 64'd1 << op_sz;
        case (disp_sz)
            2'd0: dx = {{56{disp[7]}}, disp[7:0]};
            2'd1: dx = {{48{disp[15]}}, disp[15:0]};
            default: dx = {{32{disp[31]}}, disp};
        endcase
        e_valid = in_valid; e_err = 0; e_wbv = 0; e_wb = 0; e_addr = 0; off = 0;
        otag = "R1";
        case (mode)
            0: off = dx;
            1: off = base;
            2: begin off = base + dx; otag = "R2"; end
            3: off = base + index;
            4: begin off = base + index + dx; otag = "R2"; end
            5: begin off = base + (longint'(index) << scale); otag = "R3"; end
            6: begin off = base + (longint'(index) << scale) + dx; otag = "R3"; end
            7: begin off = base; e_wbv = 1; e_wb = 32'(base + n); otag = "R7"; end
            8: begin off = base - n; e_wbv = 1; e_wb = 32'(base - n); otag = "R8"; end
            default: begin e_err = 1; otag = "R10"; end
        endcase
        if (!prot_en) begin sb = longint'(seg) * 16; lim = 64'd1 << 20; stag = "R4"; end
        else if (full_en) begin sb = mtbl[seg[2:0]]; lim = 64'd1 << 32; stag = "R5"; end
        else begin sb = mtbl[seg[2:0]] % (64'd1 << 24); lim = 64'd1 << 24; stag = "R6"; end
        if (!e_err) e_addr = 32'((sb + off) % lim);
        if (!in_valid) begin e_err = 0; e_wbv = 0; e_wb = 0; e_addr = 0; end
        e_tag = {otag, "/", stag};
        if (dt_we) mtbl[dt_idx] = dt_base;
    endtask

    task automatic compare();
        check(out_valid == e_valid, "R9 valid", 32'(out_valid), 32'(e_valid));
        check(out_err == e_err, "R10 err", 32'(out_err), 32'(e_err));
        check(out_addr == e_addr, {e_tag, " addr"}, out_addr, e_addr);
        check(wb_valid == e_wbv, "R8 wb_valid", 32'(wb_valid), 32'(e_wbv));
        check(wb_data == e_wb, "R7 wb_data", wb_data, e_wb);
    endtask

    task automatic step(input bit v, input logic [3:0] m, input logic [31:0] b,
                        input logic [31:0] ix, input logic [1:0] sc,
                        input logic [31:0] d, input logic [1:0] ds,
                        input logic [1:0] os, input logic [15:0] sg,
                        input bit pe, input bit fe);
        in_valid = v; mode = m; base = b; index = ix; scale = sc; disp = d;
        disp_sz = ds; op_sz = os; seg = sg; prot_en = pe; full_en = fe;
        model();
        @(negedge clk);
        compare();
        dt_we = 0;
    endtask

    task automatic tload(input logic [2:0] i, input logic [31:0] val);
        dt_we = 1; dt_idx = i; dt_base = val;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst = 1; in_valid = 0; mode = 0; base = 0; index = 0; scale = 0; disp = 0;
        disp_sz = 0; op_sz = 0; seg = 0; prot_en = 0; full_en = 0;
        dt_we = 0; dt_idx = 0; dt_base = 0;
        for (int i = 0; i < 8; i++) mtbl[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R12: outputs cleared by reset
        check(!out_valid && !out_err && !wb_valid && out_addr == 0 && wb_data == 0,
              "R12 reset outputs", out_addr, 0);
        // R12: table cleared, entry 5 reads zero in full protected mode
        step(1, 1, 32'h100, 0, 0, 0, 0, 0, 16'h0005, 1, 1);
        // R1: absolute, base, base+index in real mode
        step(1, 0, 0, 0, 0, 32'h0000_0080, 0, 0, 16'h1234, 0, 0);
        step(1, 1, 32'h0000_FFF0, 0, 0, 0, 0, 0, 16'hF000, 0, 0);
        step(1, 3, 32'h10, 32'h20, 3, 0, 0, 0, 16'h0001, 0, 0);
        // R2: displacement sizes
        step(1, 2, 32'h1000, 0, 0, 32'h0000_00FF, 0, 0, 0, 0, 0);
        step(1, 2, 32'h1000, 0, 0, 32'h0000_8000, 1, 0, 0, 0, 0);
        step(1, 4, 32'h1000, 32'h4, 0, 32'hFFFF_FFF0, 2, 0, 0, 0, 0);
        // R3: scaled index
        step(1, 5, 32'h100, 32'h7, 3, 0, 0, 0, 0, 0, 0);
        step(1, 6, 32'h100, 32'h7, 2, 32'h3, 3, 0, 0, 0, 0);
        // R11: load table, same-cycle lookup sees old value
        tload(3'd2, 32'hAB12_3400);
        tload(3'd6, 32'h0010_0000);
        dt_we = 1; dt_idx = 3'd2; dt_base = 32'h5555_0000;
        step(1, 1, 32'h10, 0, 0, 0, 0, 0, 16'h0002, 1, 1);
        // R5: full protected
        step(1, 1, 32'h10, 0, 0, 0, 0, 0, 16'h0002, 1, 1);
        step(1, 2, 32'hFFF0_0000, 0, 0, 32'h10, 2, 0, 16'hFFF6, 1, 1);
        // R6: reduced protected
        step(1, 1, 32'h00FF_FFFF, 0, 0, 0, 0, 0, 16'h0002, 1, 0);
        // R7: auto-increment with wrap
        step(1, 7, 32'hFFFF_FFF8, 0, 0, 0, 0, 3, 16'h0006, 1, 1);
        // R8: auto-decrement with wrap, real mode
        step(1, 8, 32'h2, 0, 0, 0, 0, 2, 16'h0000, 0, 0);
        // R10: undefined codes
        step(1, 9, 32'h1234, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 15, 32'h1234, 0, 0, 0, 0, 0, 16'h0002, 1, 1);
        // R9: idle
        step(0, 7, 32'h1234, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 800; k++) begin
            logic [31:0] r1, r2;
            r1 = nrand(); r2 = nrand();
            dt_we = r1[31:29] == 3'd0; dt_idx = r1[28:26]; dt_base = nrand();
            step(r1[0] | r1[1], 4'(r1[7:4] % 12), nrand(), nrand(), r1[9:8],
                 nrand(), r1[11:10], r1[13:12], r2[15:0], r2[16], r2[17]);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R9 watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule